// File: doc/BRIEF.md
# Register Unit with Last-Writer and Link-Count Tracking

This block widens an ordinary register file with two pieces of bookkeeping per register, so that a pre-computed branch scheme can be fed from it. Each register keeps three things:

- its data value;
- the program counter of the last instruction that wrote it (the producer PC);
- a small saturating link count.

The link count tracks how many stored branch entries read that register as a source. A separate branch table sends increment requests when it stores such an entry and decrement requests when it evicts one. The unit itself never decides what is linked.

On every register write the unit stores the new value and the writer's PC. One cycle later it reports whether the destination had a non-zero link count. That flag is the filter that lets the neighbouring branch table skip its full associative search when no stored branch depends on the written register. Two read ports return value and producer PC with one cycle of latency, and they forward a same-cycle write.

Top module: `prod_reg_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, every read output and `search_req` are zero. After reset, every register reads value 0 and producer PC 0, and every link count is 0.
- R2: A write with `wb_en` high stores `wb_data` and `wb_pc` into register `wb_rd`. A read address presented on port A in cycle t returns that register's value and producer PC on the port A outputs in cycle t+1.
- R3: When a read port addresses the register being written in the same cycle, the outputs in the next cycle show the new value and the new producer PC (write-first).
- R4: Each increment request adds one to the named register's link count. The count saturates at 3 and further increments leave it at 3.
- R5: Each decrement request subtracts one from the named register's link count. The count never goes below 0, so a decrement at 0 leaves it at 0.
- R6: Up to two increments and two decrements may arrive in one cycle, on any registers, including all four on the same register. The net change is applied once and then clamped to the range 0..3. For example, 3 + 2 − 2 stays 3, and 0 + 1 − 2 gives 0.
- R7: Register 0 has no link count. Increment and decrement requests naming register 0 have no effect, and a write to register 0 never raises `search_req`.
- R8: `search_req` is high in cycle t+1 exactly when cycle t had a write to a register other than 0 whose link count, as held at the start of cycle t (before that cycle's requests), was above 0.
- R9: Read port B behaves like port A (R2, R3) and is independent of it, so both ports may read different registers or the same one in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_en | input | 1 | Register write strobe |
| wb_rd | input | 5 | Destination register index |
| wb_data | input | 32 | Value written |
| wb_pc | input | 32 | PC of the writing instruction |
| rda_idx | input | 5 | Read port A register index |
| rda_value | output | 32 | Read port A value, one cycle later |
| rda_pc | output | 32 | Read port A producer PC, one cycle later |
| rdb_idx | input | 5 | Read port B register index |
| rdb_value | output | 32 | Read port B value, one cycle later |
| rdb_pc | output | 32 | Read port B producer PC, one cycle later |
| link_add0_en | input | 1 | First increment request |
| link_add0_idx | input | 5 | Register of first increment |
| link_add1_en | input | 1 | Second increment request |
| link_add1_idx | input | 5 | Register of second increment |
| link_drop0_en | input | 1 | First decrement request |
| link_drop0_idx | input | 5 | Register of first decrement |
| link_drop1_en | input | 1 | Second decrement request |
| link_drop1_idx | input | 5 | Register of second decrement |
| search_req | output | 1 | Last cycle's write hit a linked register |

## Verification
The assertions assume that every request input and index is driven to a known value from the first clock edge, including during reset. They also assume that the four link request ports may name any register in any combination, so that no ordering or exclusivity among them is required.

The stimulus drives every input from time zero and changes inputs only on the falling edge. It draws indices from a narrow range so that writes, reads and link requests often collide on one register, with increments biased to keep link counts off zero. Directed sequences push the counts into both saturation limits and aim requests at register 0.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam int unsigned PRT_NUM_REGS = 32;
  localparam int unsigned PRT_DATA_W   = 32;
  localparam int unsigned PRT_PC_W     = 32;
  localparam int unsigned PRT_CNT_W    = 2;
  localparam int unsigned PRT_NUM_RD   = 2;

  // One link request as seen by a single register slot.
  typedef struct packed {
    logic add_a;
    logic add_b;
    logic drop_a;
    logic drop_b;
  } link_hits_t;

endpackage

// File: rtl/prt_value_bank.sv
module prt_value_bank #(
  parameter int unsigned NUM_REGS = prt_pkg::PRT_NUM_REGS,
  parameter int unsigned DATA_W   = prt_pkg::PRT_DATA_W,
  parameter int unsigned PC_W     = prt_pkg::PRT_PC_W,
  parameter int unsigned NUM_RD   = prt_pkg::PRT_NUM_RD,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [AW-1:0]     rd_idx  [NUM_RD],
  output logic [DATA_W-1:0] rd_data [NUM_RD],
  output logic [PC_W-1:0]   rd_pc   [NUM_RD]
);

  logic [DATA_W-1:0] val_mem [NUM_REGS];
  logic [PC_W-1:0]   pc_mem  [NUM_REGS];

  // Storage: cleared on reset, written on the write strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        val_mem[r] <= '0;
        pc_mem[r]  <= '0;
      end
    end else if (wr_en) begin
      val_mem[wr_idx] <= wr_data;
      pc_mem[wr_idx]  <= wr_pc;
    end
  end

  // Registered read ports with write-first forwarding.
  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    logic fwd;
    assign fwd = wr_en && (rd_idx[g] == wr_idx);

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[g] <= '0;
        rd_pc[g]   <= '0;
      end else if (fwd) begin
        rd_data[g] <= wr_data;
        rd_pc[g]   <= wr_pc;
      end else begin
        rd_data[g] <= val_mem[rd_idx[g]];
        rd_pc[g]   <= pc_mem[rd_idx[g]];
      end
    end

    // R3: a same-cycle write to the addressed register is visible next cycle
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_idx[g] == wr_idx) |=>
        (rd_data[g] == $past(wr_data) && rd_pc[g] == $past(wr_pc)));
  end

endmodule

// File: rtl/prt_link_counter.sv
module prt_link_counter #(
  parameter int unsigned CNT_W = prt_pkg::PRT_CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  prt_pkg::link_hits_t hits,
  output logic [CNT_W-1:0]    count
);

  localparam int unsigned SW = CNT_W + 2;
  localparam logic [SW-1:0] MAXV = SW'((1 << CNT_W) - 1);

  logic [SW-1:0]    up_sum;
  logic [SW-1:0]    dn_sum;
  logic [SW-1:0]    diff;
  logic [CNT_W-1:0] next_count;

  // Net change applied once, clamped at both ends.
  always_comb begin
    up_sum = {2'b00, count}
           + {{(SW-1){1'b0}}, hits.add_a}
           + {{(SW-1){1'b0}}, hits.add_b};
    dn_sum = {{(SW-1){1'b0}}, hits.drop_a}
           + {{(SW-1){1'b0}}, hits.drop_b};
    diff   = up_sum - dn_sum;
    if (dn_sum >= up_sum) begin
      next_count = '0;
    end else if (diff > MAXV) begin
      next_count = MAXV[CNT_W-1:0];
    end else begin
      next_count = diff[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      count <= next_count;
    end
  end

  // R5: with no increment, a zero count stays at zero
  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !hits.add_a && !hits.add_b) |=> (count == '0));

  // R4: with no decrement, a full count stays full
  p_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
    (count == MAXV[CNT_W-1:0] && !hits.drop_a && !hits.drop_b)
      |=> (count == MAXV[CNT_W-1:0]));

  // R6: a cycle with no requests leaves the count unchanged
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (hits == '0) |=> $stable(count));

endmodule

// File: rtl/prt_search_gate.sv
module prt_search_gate #(
  parameter int unsigned NUM_REGS = prt_pkg::PRT_NUM_REGS,
  parameter int unsigned CNT_W    = prt_pkg::PRT_CNT_W,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_idx,
  input  logic [NUM_REGS*CNT_W-1:0] cnt_flat,
  output logic                      search_req
);

  logic [CNT_W-1:0] dest_cnt;
  logic             hit;

  always_comb begin
    dest_cnt = cnt_flat[int'(wr_idx)*CNT_W +: CNT_W];
    hit      = wr_en && (wr_idx != '0) && (dest_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      search_req <= 1'b0;
    end else begin
      search_req <= hit;
    end
  end

  // R8: the flag only follows a write to a register other than 0
  p_flag_source_r8: assert property (@(posedge clk) disable iff (rst)
    search_req |-> $past(wr_en && wr_idx != '0));

  // R7: a write to register 0 never raises the flag
  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |=> !search_req);

endmodule

// File: rtl/prod_reg_unit.sv
module prod_reg_unit #(
  parameter int unsigned NUM_REGS = prt_pkg::PRT_NUM_REGS,
  parameter int unsigned DATA_W   = prt_pkg::PRT_DATA_W,
  parameter int unsigned PC_W     = prt_pkg::PRT_PC_W,
  parameter int unsigned CNT_W    = prt_pkg::PRT_CNT_W,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_en,
  input  logic [AW-1:0]     wb_rd,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [PC_W-1:0]   wb_pc,
  input  logic [AW-1:0]     rda_idx,
  output logic [DATA_W-1:0] rda_value,
  output logic [PC_W-1:0]   rda_pc,
  input  logic [AW-1:0]     rdb_idx,
  output logic [DATA_W-1:0] rdb_value,
  output logic [PC_W-1:0]   rdb_pc,
  input  logic              link_add0_en,
  input  logic [AW-1:0]     link_add0_idx,
  input  logic              link_add1_en,
  input  logic [AW-1:0]     link_add1_idx,
  input  logic              link_drop0_en,
  input  logic [AW-1:0]     link_drop0_idx,
  input  logic              link_drop1_en,
  input  logic [AW-1:0]     link_drop1_idx,
  output logic              search_req
);

  localparam int unsigned NUM_RD = 2;

  logic [AW-1:0]     rd_idx  [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];
  logic [PC_W-1:0]   rd_pc   [NUM_RD];

  assign rd_idx[0] = rda_idx;
  assign rd_idx[1] = rdb_idx;
  assign rda_value = rd_data[0];
  assign rda_pc    = rd_pc[0];
  assign rdb_value = rd_data[1];
  assign rdb_pc    = rd_pc[1];

  prt_value_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W), .NUM_RD(NUM_RD)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wb_en),
    .wr_idx  (wb_rd),
    .wr_data (wb_data),
    .wr_pc   (wb_pc),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .rd_pc   (rd_pc)
  );

  logic [NUM_REGS*CNT_W-1:0] cnt_flat;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_link
    if (r == 0) begin : g_none
      // Register 0 keeps no link count.
      assign cnt_flat[CNT_W-1:0] = '0;
    end else begin : g_cnt
      prt_pkg::link_hits_t hits;
      logic [CNT_W-1:0]    cnt;

      assign hits.add_a  = link_add0_en  && (link_add0_idx  == AW'(r));
      assign hits.add_b  = link_add1_en  && (link_add1_idx  == AW'(r));
      assign hits.drop_a = link_drop0_en && (link_drop0_idx == AW'(r));
      assign hits.drop_b = link_drop1_en && (link_drop1_idx == AW'(r));

      prt_link_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .hits  (hits),
        .count (cnt)
      );

      assign cnt_flat[r*CNT_W +: CNT_W] = cnt;
    end
  end

  prt_search_gate #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wb_en),
    .wr_idx     (wb_rd),
    .cnt_flat   (cnt_flat),
    .search_req (search_req)
  );

  // R1: outputs are zero on the cycle after a reset cycle
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rda_value == '0 && rda_pc == '0 && rdb_value == '0 &&
             rdb_pc == '0 && !search_req));

endmodule

// File: tb/test_prod_reg_unit.sv
module test_prod_reg_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_en = 1'b0;
  logic [4:0]  wb_rd = '0;
  logic [31:0] wb_data = '0;
  logic [31:0] wb_pc = '0;
  logic [4:0]  rda_idx = '0;
  logic [4:0]  rdb_idx = '0;
  logic [31:0] rda_value, rda_pc, rdb_value, rdb_pc;
  logic        la0_en = 1'b0, la1_en = 1'b0, ld0_en = 1'b0, ld1_en = 1'b0;
  logic [4:0]  la0_idx = '0, la1_idx = '0, ld0_idx = '0, ld1_idx = '0;
  logic        search_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_val [32];
  logic [31:0] m_pc  [32];
  int          m_rc  [32];

  always #5 clk = ~clk;

  prod_reg_unit i_prod_reg_unit (
    .clk(clk), .rst(rst),
    .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .wb_pc(wb_pc),
    .rda_idx(rda_idx), .rda_value(rda_value), .rda_pc(rda_pc),
    .rdb_idx(rdb_idx), .rdb_value(rdb_value), .rdb_pc(rdb_pc),
    .link_add0_en(la0_en), .link_add0_idx(la0_idx),
    .link_add1_en(la1_en), .link_add1_idx(la1_idx),
    .link_drop0_en(ld0_en), .link_drop0_idx(ld0_idx),
    .link_drop1_en(ld1_en), .link_drop1_idx(ld1_idx),
    .search_req(search_req)
  );

  function automatic int clamp3(input int v);
    if (v < 0) return 0;
    if (v > 3) return 3;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    wb_en = 0; la0_en = 0; la1_en = 0; ld0_en = 0; ld1_en = 0;
  endtask

  // One clock: predict, let the edge happen, compare at the falling edge.
  task automatic tick(input string tag);
    logic [31:0] ea_v, ea_p, eb_v, eb_p;
    bit ba, bb, ef;
    ba   = wb_en && (rda_idx == wb_rd);
    bb   = wb_en && (rdb_idx == wb_rd);
    ea_v = ba ? wb_data : m_val[rda_idx];
    ea_p = ba ? wb_pc   : m_pc[rda_idx];
    eb_v = bb ? wb_data : m_val[rdb_idx];
    eb_p = bb ? wb_pc   : m_pc[rdb_idx];
    ef   = wb_en && (wb_rd != 0) && (m_rc[wb_rd] > 0);
    if (wb_en) begin
      m_val[wb_rd] = wb_data;
      m_pc[wb_rd]  = wb_pc;
    end
    for (int r = 1; r < 32; r++) begin
      int d;
      d = 0;
      if (la0_en && la0_idx == r) d++;
      if (la1_en && la1_idx == r) d++;
      if (ld0_en && ld0_idx == r) d--;
      if (ld1_en && ld1_idx == r) d--;
      m_rc[r] = clamp3(m_rc[r] + d);
    end
    @(posedge clk);
    @(negedge clk);
    chk(ba ? "R3 port A value" : "R2 port A value", rda_value, ea_v);
    chk(ba ? "R3 port A pc" : "R2 port A pc", rda_pc, ea_p);
    chk(bb ? "R3 port B value" : "R9 port B value", rdb_value, eb_v);
    chk(bb ? "R3 port B pc" : "R9 port B pc", rdb_pc, eb_p);
    chk(tag == "" ? "R8 search flag" : tag, {31'b0, search_req}, {31'b0, ef});
  endtask

  task automatic wr(input int r, input logic [31:0] v, input logic [31:0] p);
    wb_en = 1; wb_rd = 5'(r); wb_data = v; wb_pc = p;
  endtask

  initial begin
    for (int r = 0; r < 32; r++) begin
      m_val[r] = '0; m_pc[r] = '0; m_rc[r] = 0;
    end
    // Reset: outputs held at zero during and right after reset (R1).
    @(negedge clk);
    wr(3, 32'hdead_beef, 32'h1111_0000);
    @(negedge clk);
    chk("R1 reset value", rda_value, 32'h0);
    chk("R1 reset flag", {31'b0, search_req}, 32'h0);
    clr();
    @(negedge clk);
    rst = 0;
    // Sweep all registers after reset: zero value and pc (R1).
    for (int i = 0; i < 16; i++) begin
      rda_idx = 5'(i);
      rdb_idx = 5'(i + 16);
      tick("R1 reset flag");
    end
    chk("R1 reset link counts", {31'b0, search_req}, 32'h0);

    // R5: decrement at zero is ignored.
    clr(); ld0_en = 1; ld0_idx = 20; tick("R5");
    clr(); la0_en = 1; la0_idx = 20; tick("R5");
    clr(); wr(20, 32'h20, 32'h400); tick("R5");
    clr(); wr(20, 32'h21, 32'h404); tick("R5 count one after dec at zero");
    clr(); ld0_en = 1; ld0_idx = 20; ld1_en = 1; ld1_idx = 20; tick("R5");
    clr(); wr(20, 32'h22, 32'h408); tick("R5 floor after double dec");

    // R4: saturation at 3.
    clr(); la0_en = 1; la0_idx = 21; la1_en = 1; la1_idx = 21; tick("R4");
    clr(); la0_en = 1; la0_idx = 21; la1_en = 1; la1_idx = 21; tick("R4");
    clr(); ld0_en = 1; ld0_idx = 21; ld1_en = 1; ld1_idx = 21; tick("R4");
    clr(); wr(21, 32'h31, 32'h500); tick("R4");
    clr(); wr(21, 32'h32, 32'h504); tick("R4 count one after saturation");
    clr(); ld0_en = 1; ld0_idx = 21; tick("R4");
    clr(); wr(21, 32'h33, 32'h508); tick("R4 count zero");

    // R6: mixed requests on one register in one cycle.
    clr(); la0_en = 1; la0_idx = 22; la1_en = 1; la1_idx = 22;
    ld0_en = 1; ld0_idx = 22; tick("R6");
    clr(); la0_en = 1; la0_idx = 22; ld1_en = 1; ld1_idx = 22; tick("R6");
    clr(); wr(22, 32'h41, 32'h600); tick("R6");
    clr(); wr(22, 32'h42, 32'h604); tick("R6 net plus one");
    clr(); la0_en = 1; la0_idx = 22; la1_en = 1; la1_idx = 22;
    ld0_en = 1; ld0_idx = 22; ld1_en = 1; ld1_idx = 22;
    wr(22, 32'h43, 32'h608); tick("R6 four requests");
    clr(); ld1_en = 1; ld1_idx = 22; tick("R6");
    clr(); wr(22, 32'h44, 32'h60c); tick("R6 back to zero");

    // R7: register 0 ignores link requests and never raises the flag.
    clr(); la0_en = 1; la0_idx = 0; la1_en = 1; la1_idx = 0; tick("R7");
    clr(); wr(0, 32'h55, 32'h700); la0_en = 1; la0_idx = 0; rda_idx = 0; tick("R7");
    clr(); wr(0, 32'h56, 32'h704); rdb_idx = 0; tick("R7 write to register 0");

    // R8: flag uses the count held before the cycle's requests.
    clr(); wr(23, 32'h61, 32'h800); la0_en = 1; la0_idx = 23; tick("R8 pre-update count");
    clr(); wr(23, 32'h62, 32'h804); tick("R8 linked write");
    clr(); tick("R8 idle cycle");

    // R3/R9: both ports read the register written this cycle.
    clr(); wr(23, 32'h63, 32'h808); rda_idx = 23; rdb_idx = 23; tick("");
    clr(); rda_idx = 20; rdb_idx = 21; tick("");

    // Constrained random traffic on a narrow index range.
    void'($urandom(32'h5eed));
    for (int n = 0; n < 600; n++) begin
      clr();
      wb_en   = ($urandom % 2) == 0;
      wb_rd   = 5'($urandom % 8);
      wb_data = $urandom;
      wb_pc   = $urandom & 32'hffff_fffc;
      rda_idx = 5'(($urandom % 4 == 0) ? ($urandom % 32) : ($urandom % 8));
      rdb_idx = 5'($urandom % 8);
      la0_en  = ($urandom % 3) == 0; la0_idx = 5'($urandom % 8);
      la1_en  = ($urandom % 5) == 0; la1_idx = 5'($urandom % 8);
      ld0_en  = ($urandom % 4) == 0; ld0_idx = 5'($urandom % 8);
      ld1_en  = ($urandom % 7) == 0; ld1_idx = 5'($urandom % 8);
      tick("");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule